// File: doc/BRIEF.md
# Privilege Stack Trap Controller

This block keeps the machine status word of a processor core together with a three-level stack of privilege mode and interrupt-enable pairs. It sequences trap entry and trap return. When a trap is taken, the stack is pushed and the core enters machine mode with interrupts off. The cause and the faulting PC are latched, and the next PC is set to a vector that depends on the privilege the core held when the trap arrived. When a trap return is taken, the stack is popped and the next PC is set to the saved exception PC.

Software changes the status word through a single write port. That port drops any privilege value that is not a legal encoding and still applies the other writable fields. The readable status word carries a summary dirty bit in its top position. Fetch, decode and translation are not modelled: the block only produces the next PC and the mode and enable state that those stages consume.

Status word layout (bit 0 upward): current privilege [1:0], current enable [2], level-1 privilege [4:3], level-1 enable [5], level-2 privilege [7:6], level-2 enable [8], modify-privilege flag [9], FP-state field [11:10], extension-state field [13:12], summary dirty bit [XLEN-1]. All other bits read as zero. Privilege codes are user 2'b00, supervisor 2'b01 and machine 2'b11. The code 2'b10 is illegal.

Top module: `priv_trap_ctrl`

## Requirements
- R1: A trap moves level 1 into level 2 and moves the current privilege and enable into level 1. The current privilege then becomes machine (2'b11), the current enable becomes 0 and the modify-privilege flag (bit 9) is cleared.
- R2: A return (with no trap in the same cycle) moves level 1 into the current level and level 2 into level 1. Level 2 becomes user (2'b00) with enable 1, and next_pc is loaded with the exception PC.
- R3: On a trap, next_pc becomes VEC_BASE + 0x40 × the privilege code held before the trap (0x100, 0x140 or 0x1C0 with the default base of 0x100).
- R4: A trap stores its faulting PC in epc_rd and its cause in cause_rd, one cycle after the request.
- R5: cause_rd bit XLEN-1 equals trap_irq, and bits XLEN-2:0 equal those of trap_cause. The top bit of trap_cause is not used.
- R6: After reset, the current privilege is machine and levels 1 and 2 are supervisor. All enables, flags, fields, the cause and the epc are zero, and next_pc is VEC_BASE + 0x100. The status word reads 0x4B.
- R7: A status write updates each privilege field only when the written code is not 2'b10. An illegal code keeps the field's old value, while the enables, the modify-privilege flag and both state fields still take the written value.
- R8: Status bit XLEN-1 reads 1 exactly when the FP-state field or the extension-state field is 2'b11.
- R9: Priority is trap over return over status write. A trap in the same cycle as a return and a write behaves as a trap alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trap_req | input | 1 | Take a trap this cycle |
| trap_irq | input | 1 | The trap is an interrupt |
| trap_cause | input | XLEN | Cause code; the top bit is not used |
| trap_pc | input | XLEN | PC of the trapping instruction |
| ret_req | input | 1 | Take a trap return this cycle |
| csr_we | input | 1 | Write the status word |
| csr_wdata | input | XLEN | Status word write value |
| next_pc | output | XLEN | PC that fetch uses next |
| cur_priv | output | 2 | Current privilege code |
| glob_ie | output | 1 | Current global interrupt enable |
| status_rd | output | XLEN | Readable status word with dirty bit |
| cause_rd | output | XLEN | Latched trap cause |
| epc_rd | output | XLEN | Latched exception PC |

## Verification
A vector sequence interleaves status writes, traps and returns so that traps are taken from user, supervisor and machine mode. This separates the three vector offsets and shows that each level moves into its own slot. Back-to-back traps and back-to-back returns show that level 2 is both refilled and drained in the right order. Writes with illegal privilege codes show each field held on its own, and the dirty-bit writes set the FP-state field and the extension-state field in turn. A combined trap, return and write cycle shows the priority, and interrupt and non-interrupt traps show how the cause top bit is formed.

// File: rtl/trap_pkg.sv
package trap_pkg;

    typedef enum logic [1:0] {
        PRIV_USR = 2'b00,
        PRIV_SUP = 2'b01,
        PRIV_RSV = 2'b10,
        PRIV_MCH = 2'b11
    } priv_e;

    // one stack level: enable above privilege
    typedef struct packed {
        logic  ie;
        priv_e prv;
    } lvl_t;

    // architectural status fields, bit 0 upward: l0, l1, l2, mprv, fs, xs
    typedef struct packed {
        logic [1:0] xs;
        logic [1:0] fs;
        logic       mprv;
        lvl_t       l2;
        lvl_t       l1;
        lvl_t       l0;
    } stat_t;

    localparam int STAT_W = $bits(stat_t);

    function automatic logic priv_legal(input priv_e p);
        return p != PRIV_RSV;
    endfunction

    // apply a software write, keeping any privilege field written with an illegal code
    function automatic stat_t stat_merge(input stat_t cur, input stat_t wr);
        stat_t r;
        r = wr;
        if (!priv_legal(wr.l0.prv)) r.l0.prv = cur.l0.prv;
        if (!priv_legal(wr.l1.prv)) r.l1.prv = cur.l1.prv;
        if (!priv_legal(wr.l2.prv)) r.l2.prv = cur.l2.prv;
        return r;
    endfunction

    function automatic logic stat_dirty(input stat_t s);
        return (s.fs == 2'b11) || (s.xs == 2'b11);
    endfunction

endpackage

// File: rtl/priv_stack.sv
module priv_stack
    import trap_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  push_go,
    input  logic  pop_go,
    input  logic  wr_go,
    input  stat_t wr_val,
    output stat_t stat_q
);

    localparam stat_t RST_STAT = '{
        xs: 2'b00, fs: 2'b00, mprv: 1'b0,
        l2: '{ie: 1'b0, prv: PRIV_SUP},
        l1: '{ie: 1'b0, prv: PRIV_SUP},
        l0: '{ie: 1'b0, prv: PRIV_MCH}
    };

    stat_t stat_d;

    always_comb begin
        stat_d = stat_q;
        if (push_go) begin
            stat_d.l2     = stat_q.l1;
            stat_d.l1     = stat_q.l0;
            stat_d.l0.prv = PRIV_MCH;
            stat_d.l0.ie  = 1'b0;
            stat_d.mprv   = 1'b0;
        end else if (pop_go) begin
            stat_d.l0     = stat_q.l1;
            stat_d.l1     = stat_q.l2;
            stat_d.l2.prv = PRIV_USR;
            stat_d.l2.ie  = 1'b1;
        end else if (wr_go) begin
            stat_d = stat_merge(stat_q, wr_val);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) stat_q <= RST_STAT;
        else     stat_q <= stat_d;
    end

    AST_PUSH_SHIFT: assert property (@(posedge clk) disable iff (rst)
        push_go |=> (stat_q.l1 == $past(stat_q.l0)) && (stat_q.l2 == $past(stat_q.l1))
                    && (stat_q.l0.prv == PRIV_MCH) && !stat_q.l0.ie && !stat_q.mprv); // R1

    AST_POP_SHIFT: assert property (@(posedge clk) disable iff (rst)
        (pop_go && !push_go) |=> (stat_q.l0 == $past(stat_q.l1)) && (stat_q.l1 == $past(stat_q.l2))
                    && (stat_q.l2.prv == PRIV_USR) && stat_q.l2.ie); // R2

    AST_PRIV_LEGAL: assert property (@(posedge clk) disable iff (rst)
        priv_legal(stat_q.l0.prv) && priv_legal(stat_q.l1.prv) && priv_legal(stat_q.l2.prv)); // R7

endmodule

// File: rtl/trap_regs.sv
module trap_regs
    import trap_pkg::*;
#(
    parameter int          XLEN     = 32,
    parameter logic [31:0] VEC_BASE = 32'h100
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            take_go,
    input  logic            back_go,
    input  logic            irq_flag,
    input  logic [XLEN-1:0] cause_in,
    input  logic [XLEN-1:0] fault_pc,
    input  priv_e           pre_priv,
    output logic [XLEN-1:0] pc_q,
    output logic [XLEN-1:0] cause_q,
    output logic [XLEN-1:0] epc_q
);

    localparam logic [XLEN-1:0] BASE_X  = XLEN'(VEC_BASE);
    localparam logic [XLEN-1:0] RESET_PC = BASE_X + XLEN'(32'h100);
    localparam int              SLOT_SH  = 6;

    logic [XLEN-1:0] vec_pc;

    always_comb vec_pc = BASE_X + (XLEN'(pre_priv) << SLOT_SH);

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q    <= RESET_PC;
            cause_q <= '0;
            epc_q   <= '0;
        end else if (take_go) begin
            pc_q    <= vec_pc;
            cause_q <= {irq_flag, cause_in[XLEN-2:0]};
            epc_q   <= fault_pc;
        end else if (back_go) begin
            pc_q    <= epc_q;
        end
    end

    AST_EPC_LATCH: assert property (@(posedge clk) disable iff (rst)
        take_go |=> epc_q == $past(fault_pc)); // R4

    AST_IRQ_FLAG: assert property (@(posedge clk) disable iff (rst)
        take_go |=> cause_q[XLEN-1] == $past(irq_flag)); // R5

    AST_RET_PC: assert property (@(posedge clk) disable iff (rst)
        (back_go && !take_go) |=> pc_q == $past(epc_q)); // R2

endmodule

// File: rtl/priv_trap_ctrl.sv
module priv_trap_ctrl
    import trap_pkg::*;
#(
    parameter int          XLEN     = 32,
    parameter logic [31:0] VEC_BASE = 32'h100
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            trap_req,
    input  logic            trap_irq,
    input  logic [XLEN-1:0] trap_cause,
    input  logic [XLEN-1:0] trap_pc,
    input  logic            ret_req,
    input  logic            csr_we,
    input  logic [XLEN-1:0] csr_wdata,
    output logic [XLEN-1:0] next_pc,
    output logic [1:0]      cur_priv,
    output logic            glob_ie,
    output logic [XLEN-1:0] status_rd,
    output logic [XLEN-1:0] cause_rd,
    output logic [XLEN-1:0] epc_rd
);

    localparam int PAD_W = XLEN - 1 - STAT_W;

    stat_t stat;
    logic  do_trap, do_ret, do_wr;

    // trap beats return, return beats a status write
    always_comb begin
        do_trap = trap_req;
        do_ret  = ret_req && !trap_req;
        do_wr   = csr_we && !trap_req && !ret_req;
    end

    priv_stack u_stack (
        .clk     (clk),
        .rst     (rst),
        .push_go (do_trap),
        .pop_go  (do_ret),
        .wr_go   (do_wr),
        .wr_val  (stat_t'(csr_wdata[STAT_W-1:0])),
        .stat_q  (stat)
    );

    trap_regs #(.XLEN(XLEN), .VEC_BASE(VEC_BASE)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .take_go  (do_trap),
        .back_go  (do_ret),
        .irq_flag (trap_irq),
        .cause_in (trap_cause),
        .fault_pc (trap_pc),
        .pre_priv (stat.l0.prv),
        .pc_q     (next_pc),
        .cause_q  (cause_rd),
        .epc_q    (epc_rd)
    );

    always_comb begin
        cur_priv  = stat.l0.prv;
        glob_ie   = stat.l0.ie;
        status_rd = {stat_dirty(stat), {PAD_W{1'b0}}, stat};
    end

    AST_TRAP_VECTOR: assert property (@(posedge clk) disable iff (rst)
        trap_req |=> next_pc == XLEN'(VEC_BASE) + XLEN'({$past(cur_priv), 6'b0})); // R3

    AST_TRAP_MODE: assert property (@(posedge clk) disable iff (rst)
        trap_req |=> (cur_priv == 2'b11) && !glob_ie); // R1

    AST_TRAP_WINS: assert property (@(posedge clk) disable iff (rst)
        (trap_req && ret_req) |=> (cur_priv == 2'b11) && (epc_rd == $past(trap_pc))); // R9

endmodule

// File: tb/priv_trap_ctrl_test.sv
module priv_trap_ctrl_test;

    localparam int XLEN = 32;
    localparam int NV   = 8;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            trap_req = 1'b0, trap_irq = 1'b0, ret_req = 1'b0, csr_we = 1'b0;
    logic [XLEN-1:0] trap_cause = '0, trap_pc = '0, csr_wdata = '0;
    logic [XLEN-1:0] next_pc, status_rd, cause_rd, epc_rd;
    logic [1:0]      cur_priv;
    logic            glob_ie;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    priv_trap_ctrl #(.XLEN(XLEN), .VEC_BASE(32'h100)) uut (
        .clk(clk), .rst(rst), .trap_req(trap_req), .trap_irq(trap_irq),
        .trap_cause(trap_cause), .trap_pc(trap_pc), .ret_req(ret_req),
        .csr_we(csr_we), .csr_wdata(csr_wdata), .next_pc(next_pc),
        .cur_priv(cur_priv), .glob_ie(glob_ie), .status_rd(status_rd),
        .cause_rd(cause_rd), .epc_rd(epc_rd)
    );

    // op: 0 trap (data = faulting pc), 1 return, 2 status write (data = value)
    typedef struct packed {
        logic [1:0]  op;
        logic [31:0] data;
        logic [1:0]  e_priv;
        logic        e_ie;
        logic [31:0] e_pc;
        logic [31:0] e_stat;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{2'd2, 32'h0000_02EC, 2'd0, 1'b1, 32'h0000_0200, 32'h0000_02EC}, // R7 legal write
        '{2'd0, 32'h0000_1000, 2'd3, 1'b0, 32'h0000_0100, 32'h0000_0163}, // R1 R3 from user
        '{2'd1, 32'h0,         2'd0, 1'b1, 32'h0000_1000, 32'h0000_012C}, // R2
        '{2'd2, 32'h0000_0149, 2'd1, 1'b0, 32'h0000_1000, 32'h0000_0149}, // R7
        '{2'd0, 32'h0000_2000, 2'd3, 1'b0, 32'h0000_0140, 32'h0000_004B}, // R3 from supervisor
        '{2'd0, 32'h0000_3000, 2'd3, 1'b0, 32'h0000_01C0, 32'h0000_005B}, // R3 from machine
        '{2'd1, 32'h0,         2'd3, 1'b0, 32'h0000_3000, 32'h0000_010B}, // R2
        '{2'd1, 32'h0,         2'd1, 1'b0, 32'h0000_3000, 32'h0000_0121}  // R2 refill
    };

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic cycle(input bit t, input bit r, input bit w, input logic [31:0] d,
                         input bit irq, input logic [31:0] c);
        @(negedge clk);
        trap_req = t; ret_req = r; csr_we = w; trap_irq = irq; trap_cause = c;
        trap_pc = d; csr_wdata = d;
        @(negedge clk);
        trap_req = 0; ret_req = 0; csr_we = 0; trap_irq = 0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'd0, 32'd1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R6 reset state
        check(status_rd == 32'h4B, "R6 status", status_rd, 32'h4B);
        check(next_pc == 32'h200, "R6 pc", next_pc, 32'h200);
        check(cur_priv == 2'd3 && !glob_ie, "R6 priv", {30'd0, cur_priv}, 32'd3);
        check(cause_rd == 0 && epc_rd == 0, "R6 cause/epc", cause_rd | epc_rd, 32'd0);

        for (int i = 0; i < NV; i++) begin
            vec_t v = VECS[i];
            cycle(v.op == 2'd0, v.op == 2'd1, v.op == 2'd2, v.data, 1'b0, 32'd11);
            check(status_rd == v.e_stat, $sformatf("R1/R2/R7 vec%0d status", i), status_rd, v.e_stat);
            check(next_pc == v.e_pc, $sformatf("R3/R2 vec%0d pc", i), next_pc, v.e_pc);
            check(cur_priv == v.e_priv && glob_ie == v.e_ie, $sformatf("R1/R2 vec%0d priv", i),
                  {29'd0, glob_ie, cur_priv}, {29'd0, v.e_ie, v.e_priv});
            if (v.op == 2'd0) begin
                check(epc_rd == v.data, $sformatf("R4 vec%0d epc", i), epc_rd, v.data);
                check(cause_rd == 32'd11, $sformatf("R4 vec%0d cause", i), cause_rd, 32'd11);
            end
        end

        // R7 R8 illegal privilege codes held, other fields written, fs dirty
        do_reset();
        cycle(0, 0, 1, 32'h0000_0C86, 0, 0);
        check(status_rd == 32'h8000_0C47, "R7 illegal prv held", status_rd, 32'h8000_0C47);
        // R8 extension-state field dirty
        cycle(0, 0, 1, 32'h0000_3403, 0, 0);
        check(status_rd == 32'h8000_3403, "R8 xs dirty", status_rd, 32'h8000_3403);
        // R8 neither field all ones
        cycle(0, 0, 1, 32'h0000_1803, 0, 0);
        check(status_rd == 32'h0000_1803, "R8 not dirty", status_rd, 32'h0000_1803);

        // R5 interrupt flag and ignored top bit of the cause
        cycle(1, 0, 0, 32'h0000_5000, 1, 32'h0000_0007);
        check(cause_rd == 32'h8000_0007, "R5 irq cause", cause_rd, 32'h8000_0007);
        check(epc_rd == 32'h0000_5000, "R4 epc irq", epc_rd, 32'h0000_5000);
        cycle(1, 0, 0, 32'h0000_6000, 0, 32'h8000_0003);
        check(cause_rd == 32'h0000_0003, "R5 exc cause", cause_rd, 32'h0000_0003);

        // R9 trap, return and write in one cycle act as a trap
        do_reset();
        cycle(1, 1, 1, 32'h0000_4444, 0, 32'd2);
        check(status_rd == 32'h5B, "R9 status", status_rd, 32'h5B);
        check(next_pc == 32'h1C0, "R9 pc", next_pc, 32'h1C0);
        check(epc_rd == 32'h4444, "R9 epc", epc_rd, 32'h4444);
        // R9 return beats a write
        cycle(0, 1, 1, 32'h0000_0000, 0, 0);
        check(status_rd == 32'h10B, "R9 ret over write", status_rd, 32'h10B);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule